// File: doc/BRIEF.md
# Block Address Translation Matcher

This block decides whether an effective address falls inside one of a small set of large, software-defined translation blocks. If it does, the block gives the real address and the access rights for that block. It keeps two banks of entries. Instruction fetches are looked up in one bank, and loads and stores are looked up in the other. Each entry is a pair of 32-bit words, an upper word and a lower word. Software loads these words through a plain write port that selects the bank, the entry and the half.

The upper word holds three things: the effective block base, a length field that widens the block, and two enable bits, one per privilege mode. The lower word holds the real block base and a two-bit rights code. All entries are compared in parallel and the lowest-numbered matching entry wins. The result is either a hit, with a page-aligned real address and a read/write/execute set, or a miss, with address and rights forced to zero.

The result is normally captured in a register stage, which can be removed by a parameter. Segment lookup, table walks and fault raising happen elsewhere.

Top module: `blockXlateMatch`

## Requirements
- R1: When `isFetch` is 1 the lookup searches the instruction bank (`wrBank`=0); when it is 0 it searches the data bank (`wrBank`=1). Entries of the other bank never affect the result.
- R2: An entry can match only if its upper-word bit 1 is set for a supervisor access (`userMode`=0), or its upper-word bit 0 is set for a user access (`userMode`=1).
- R3: The compare mask is 0xFFFE0000 with address bits 27:17 cleared wherever upper-word bits 12:2 are set. An entry matches when `effAddr` AND mask equals upper-word bits 31:17 (with the lower 17 bits taken as zero).
- R4: On a hit, `realAddr` takes lower-word bits where the mask is 1 and `effAddr` bits where it is 0. Bits 11:0 of `realAddr` are always zero.
- R5: Lower-word bits 1:0 give the rights. For `perm`, bit 0 is read, bit 1 is write and bit 2 is execute. Code 0 gives 3'b000, code 2 gives 3'b111, and codes 1 and 3 give 3'b101. A matching entry with code 0 still reports a hit.
- R6: When several entries match, the one with the lowest index decides the result.
- R7: When no entry matches, `miss`=1, `hit`=0, `realAddr`=0 and `perm`=0.
- R8: With `REG_OUT`=1, the result for inputs present before a rising clock edge appears after that edge and holds until the next one. After reset the outputs show `miss`=1 with everything else zero.
- R9: A write with `wrEn`=1 stores `wrData` into entry `wrIdx` of bank `wrBank`: the upper word when `wrUpper`=1 and the lower word otherwise. A write with `wrIdx` >= `NUM_ENTRIES` changes nothing.
- R10: With `NUM_ENTRIES`=0 every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Entry write strobe |
| wrBank | input | 1 | 0 instruction bank, 1 data bank |
| wrUpper | input | 1 | 1 writes the upper word, 0 the lower word |
| wrIdx | input | IDX_W | Entry index of the write |
| wrData | input | 32 | Word to store |
| isFetch | input | 1 | Lookup is an instruction fetch |
| userMode | input | 1 | Lookup is made in user mode |
| effAddr | input | 32 | Effective address to translate |
| hit | output | 1 | An entry matched |
| miss | output | 1 | No entry matched |
| realAddr | output | 32 | Page-aligned real address, zero on miss |
| perm | output | 3 | {execute, write, read}, zero on miss |

## Verification
The same address is looked up with the mode flag flipped. This separates the two enable bits and shows which of two overlapping entries takes priority. The same address is also looked up as a fetch and as a data access, which separates the banks.

Three block lengths are used: the smallest block, a 512 KB block and a full 256 MB block. Addresses are placed just inside and just outside the top edge of each block, so that a mask that is off by one bit shows up as a wrong hit or miss. An entry with rights code 0 separates a hit with no rights from a miss.

Further directed checks cover three more cases: an out-of-range write, the one-cycle result latency, and a zero-entry instance.

// File: rtl/blockXlatePkg.sv
package blockXlatePkg;

  localparam logic [31:0] EPI_FIELD  = 32'hFFFE_0000;
  localparam logic [31:0] LEN_FIELD  = 32'h0000_1FFC;
  localparam int          LEN_SHIFT  = 15;
  localparam logic [31:0] PAGE_KEEP  = 32'hFFFF_F000;

  // Rights code from lower word bits 1:0
  localparam logic [1:0]  RIGHTS_NONE = 2'd0;
  localparam logic [1:0]  RIGHTS_FULL = 2'd2;

  // perm vector bit positions
  localparam int PERM_RD = 0;
  localparam int PERM_WR = 1;
  localparam int PERM_EX = 2;

  typedef struct packed {
    logic wrInstUp;
    logic wrInstLo;
    logic wrDataUp;
    logic wrDataLo;
    logic useData;
    logic userKey;
  } batStrobes_t;

endpackage

// File: rtl/blockXlateCtrl.sv
module blockXlateCtrl
  import blockXlatePkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int IDX_W       = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrBank,
  input  logic             wrUpper,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic             isFetch,
  input  logic             userMode,
  output batStrobes_t      strobes
);

  logic idxOk;

  assign idxOk = (32'(wrIdx) < 32'(NUM_ENTRIES));

  always_comb begin
    strobes          = '0;
    strobes.wrInstUp = wrEn && idxOk && !wrBank &&  wrUpper;
    strobes.wrInstLo = wrEn && idxOk && !wrBank && !wrUpper;
    strobes.wrDataUp = wrEn && idxOk &&  wrBank &&  wrUpper;
    strobes.wrDataLo = wrEn && idxOk &&  wrBank && !wrUpper;
    strobes.useData  = !isFetch;
    strobes.userKey  = userMode;
  end

  AST_ONE_WRITE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.wrInstUp, strobes.wrInstLo, strobes.wrDataUp, strobes.wrDataLo})); // R9

endmodule

// File: rtl/blockXlateDp.sv
module blockXlateDp
  import blockXlatePkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int IDX_W       = 3,
  parameter bit REG_OUT     = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  batStrobes_t      strobes,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [31:0]      wrData,
  input  logic [31:0]      effAddr,
  output logic             hit,
  output logic             miss,
  output logic [31:0]      realAddr,
  output logic [2:0]       perm
);

  localparam int NE      = (NUM_ENTRIES > 0) ? NUM_ENTRIES : 1;
  localparam bit ENABLED = (NUM_ENTRIES > 0);

  logic [31:0] instUp [NE];
  logic [31:0] instLo [NE];
  logic [31:0] dataUp [NE];
  logic [31:0] dataLo [NE];

  logic [NE-1:0] entryHit;
  logic [31:0]   entryAddr [NE];
  logic [2:0]    entryPerm [NE];
  logic [NE-1:0] firstSel;

  logic        combHit;
  logic [31:0] combAddr;
  logic [2:0]  combPerm;

  // Entry storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NE; i++) begin
        instUp[i] <= '0;
        instLo[i] <= '0;
        dataUp[i] <= '0;
        dataLo[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NE; i++) begin
        if (wrIdx == IDX_W'(i)) begin
          if (strobes.wrInstUp) instUp[i] <= wrData;
          if (strobes.wrInstLo) instLo[i] <= wrData;
          if (strobes.wrDataUp) dataUp[i] <= wrData;
          if (strobes.wrDataLo) dataLo[i] <= wrData;
        end
      end
    end
  end

  // Parallel per-entry compare
  for (genvar g = 0; g < NE; g++) begin : gEntry
    logic [31:0] selUp;
    logic [31:0] selLo;
    logic [31:0] cmpMask;
    logic        keyOk;

    assign selUp   = strobes.useData ? dataUp[g] : instUp[g];
    assign selLo   = strobes.useData ? dataLo[g] : instLo[g];
    assign keyOk   = strobes.userKey ? selUp[0] : selUp[1];
    assign cmpMask = EPI_FIELD & ~((selUp & LEN_FIELD) << LEN_SHIFT);

    assign entryHit[g]  = ENABLED && keyOk &&
                          ((effAddr & cmpMask) == (selUp & EPI_FIELD));
    assign entryAddr[g] = ((selLo & cmpMask) | (effAddr & ~cmpMask)) & PAGE_KEEP;

    always_comb begin
      if (selLo[1:0] == RIGHTS_NONE)      entryPerm[g] = 3'b000;
      else if (selLo[1:0] == RIGHTS_FULL) entryPerm[g] = 3'b111;
      else                                entryPerm[g] = 3'b101;
    end
  end

  // Lowest index wins
  always_comb begin
    firstSel = '0;
    combHit  = 1'b0;
    combAddr = '0;
    combPerm = '0;
    for (int i = 0; i < NE; i++) begin
      if (entryHit[i] && !combHit) begin
        firstSel[i] = 1'b1;
        combHit     = 1'b1;
        combAddr    = entryAddr[i];
        combPerm    = entryPerm[i];
      end
    end
  end

  if (REG_OUT) begin : gReg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        hit      <= 1'b0;
        miss     <= 1'b1;
        realAddr <= '0;
        perm     <= '0;
      end else begin
        hit      <= combHit;
        miss     <= !combHit;
        realAddr <= combAddr;
        perm     <= combPerm;
      end
    end
  end else begin : gComb
    assign hit      = combHit;
    assign miss     = !combHit;
    assign realAddr = combAddr;
    assign perm     = combPerm;
  end

  AST_FIRST_HIT_UNIQUE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(firstSel)); // R6
  AST_PAGE_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    realAddr[11:0] == 12'h000); // R4
  AST_WRITE_NEEDS_RX: assert property (@(posedge clk) disable iff (!rstN)
    perm[PERM_WR] |-> (perm[PERM_RD] && perm[PERM_EX])); // R5
  AST_MISS_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    miss |-> (!hit && realAddr == 32'h0 && perm == 3'b000)); // R7
  AST_ZERO_ENTRIES_MISS: assert property (@(posedge clk) disable iff (!rstN)
    !ENABLED |-> !combHit); // R10

endmodule

// File: rtl/blockXlateMatch.sv
module blockXlateMatch
  import blockXlatePkg::*;
#(
  parameter int  NUM_ENTRIES = 4,
  parameter bit  REG_OUT     = 1'b1,
  localparam int IDX_W       = ($clog2(NUM_ENTRIES + 1) > 0) ? $clog2(NUM_ENTRIES + 1) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrBank,
  input  logic             wrUpper,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [31:0]      wrData,
  input  logic             isFetch,
  input  logic             userMode,
  input  logic [31:0]      effAddr,
  output logic             hit,
  output logic             miss,
  output logic [31:0]      realAddr,
  output logic [2:0]       perm
);

  batStrobes_t strobes;

  blockXlateCtrl #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrBank   (wrBank),
    .wrUpper  (wrUpper),
    .wrIdx    (wrIdx),
    .isFetch  (isFetch),
    .userMode (userMode),
    .strobes  (strobes)
  );

  blockXlateDp #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W), .REG_OUT(REG_OUT)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wrIdx    (wrIdx),
    .wrData   (wrData),
    .effAddr  (effAddr),
    .hit      (hit),
    .miss     (miss),
    .realAddr (realAddr),
    .perm     (perm)
  );

endmodule

// File: tb/blockXlateMatch_tb_top.sv
module blockXlateMatch_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        wrBank = 1'b0;
  logic        wrUpper = 1'b0;
  logic [2:0]  wrIdx = '0;
  logic [31:0] wrData = '0;
  logic        isFetch = 1'b0;
  logic        userMode = 1'b0;
  logic [31:0] effAddr = '0;
  logic        hit, miss;
  logic [31:0] realAddr;
  logic [2:0]  perm;
  logic        hit0, miss0;
  logic [31:0] realAddr0;
  logic [2:0]  perm0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  blockXlateMatch #(.NUM_ENTRIES(4), .REG_OUT(1'b1)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrBank(wrBank), .wrUpper(wrUpper),
    .wrIdx(wrIdx), .wrData(wrData), .isFetch(isFetch), .userMode(userMode),
    .effAddr(effAddr), .hit(hit), .miss(miss), .realAddr(realAddr), .perm(perm)
  );

  // Zero-entry variant (R10)
  blockXlateMatch #(.NUM_ENTRIES(0), .REG_OUT(1'b1)) dutZero_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrBank(wrBank), .wrUpper(wrUpper),
    .wrIdx(wrIdx[0]), .wrData(wrData), .isFetch(isFetch), .userMode(userMode),
    .effAddr(effAddr), .hit(hit0), .miss(miss0), .realAddr(realAddr0), .perm(perm0)
  );

  // {fetch, user, effAddr, expHit, expAddr, expPerm}
  typedef logic [69:0] vec_t;
  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    {1'b0, 1'b0, 32'h1001_2345, 1'b1, 32'h8001_2000, 3'b111},  // super hits D0 (R2 R6)
    {1'b0, 1'b1, 32'h1001_2345, 1'b1, 32'h9001_2000, 3'b101},  // user skips D0, hits D2 (R2)
    {1'b0, 1'b0, 32'h2ABC_DEF0, 1'b1, 32'h4ABC_D000, 3'b101},  // 256MB block (R3 R4)
    {1'b0, 1'b0, 32'h1002_0000, 1'b0, 32'h0,         3'b000},  // just past 128KB (R3 R7)
    {1'b0, 1'b1, 32'h3000_0FFF, 1'b1, 32'h5000_0000, 3'b000},  // hit with no rights (R5)
    {1'b0, 1'b0, 32'h3000_0FFF, 1'b0, 32'h0,         3'b000},  // user-only entry, super (R2)
    {1'b1, 1'b0, 32'h1001_2345, 1'b1, 32'hA001_2000, 3'b111},  // fetch bank (R1)
    {1'b1, 1'b1, 32'h2ABC_DEF0, 1'b0, 32'h0,         3'b000},  // data-only block on fetch (R1)
    {1'b0, 1'b0, 32'h1001_FFFF, 1'b1, 32'h8001_F000, 3'b111},  // top of 128KB (R3 R4)
    {1'b1, 1'b0, 32'h1002_0000, 1'b0, 32'h0,         3'b000},  // fetch past block (R3)
    {1'b1, 1'b1, 32'h6007_8ABC, 1'b1, 32'h7007_8000, 3'b101},  // 512KB block top (R3 R4)
    {1'b1, 1'b1, 32'h6008_0000, 1'b0, 32'h0,         3'b000}   // past 512KB (R3)
  };

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic check(input bit ok, input string tag, input logic [69:0] act, input logic [69:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic writeWord(input bit bank, input bit upper, input logic [2:0] idx, input logic [31:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrBank = bank; wrUpper = upper; wrIdx = idx; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic lookup(input bit fetch, input bit user, input logic [31:0] ea);
    @(negedge clk);
    isFetch = fetch; userMode = user; effAddr = ea;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    check(miss && !hit && realAddr == 0 && perm == 0, "R8 reset state",
          {hit, miss, realAddr, perm}, {1'b0, 1'b1, 32'h0, 3'b000});
    rstN = 1'b1;

    // R9: load entries
    writeWord(1'b1, 1'b1, 3'd0, 32'h1000_0002); writeWord(1'b1, 1'b0, 3'd0, 32'h8000_0002);
    writeWord(1'b1, 1'b1, 3'd1, 32'h2000_1FFF); writeWord(1'b1, 1'b0, 3'd1, 32'h4000_0001);
    writeWord(1'b1, 1'b1, 3'd2, 32'h1000_0003); writeWord(1'b1, 1'b0, 3'd2, 32'h9000_0003);
    writeWord(1'b1, 1'b1, 3'd3, 32'h3000_0001); writeWord(1'b1, 1'b0, 3'd3, 32'h5000_0000);
    writeWord(1'b0, 1'b1, 3'd0, 32'h1000_0003); writeWord(1'b0, 1'b0, 3'd0, 32'hA000_0002);
    writeWord(1'b0, 1'b1, 3'd1, 32'h6000_000F); writeWord(1'b0, 1'b0, 3'd1, 32'h7000_0001);
    // R9: out-of-range index must not land anywhere
    writeWord(1'b1, 1'b1, 3'd4, 32'h4000_0003); writeWord(1'b1, 1'b0, 3'd4, 32'hC000_0002);

    for (int v = 0; v < NVEC; v++) begin
      lookup(VECS[v][69], VECS[v][68], VECS[v][67:36]);
      check(hit == VECS[v][35] && miss == !VECS[v][35] &&
            realAddr == VECS[v][34:3] && perm == VECS[v][2:0],
            $sformatf("vector %0d (R1 R2 R3 R4 R5 R6 R7)", v),
            {hit, miss, realAddr, perm}, {VECS[v][35], !VECS[v][35], VECS[v][34:3], VECS[v][2:0]});
    end

    // R9: out-of-range write ignored
    lookup(1'b0, 1'b0, 32'h4000_0000);
    check(miss && !hit && realAddr == 0, "R9 out-of-range write ignored",
          {hit, miss, realAddr, perm}, {1'b0, 1'b1, 32'h0, 3'b000});

    // R9: overwriting an upper word moves the block
    writeWord(1'b1, 1'b1, 3'd3, 32'h3100_0001);
    lookup(1'b0, 1'b1, 32'h3100_0123);
    check(hit && realAddr == 32'h5000_0000, "R9 rewritten upper word",
          {hit, miss, realAddr, perm}, {1'b1, 1'b0, 32'h5000_0000, 3'b000});

    // R8: latency, result holds until next edge
    lookup(1'b0, 1'b0, 32'h1001_2345);
    effAddr = 32'h0000_0000;
    #1;
    check(hit && realAddr == 32'h8001_2000, "R8 result held before edge",
          {hit, miss, realAddr, perm}, {1'b1, 1'b0, 32'h8001_2000, 3'b111});
    @(negedge clk);
    check(miss && !hit, "R8 result updates after edge",
          {hit, miss, realAddr, perm}, {1'b0, 1'b1, 32'h0, 3'b000});

    // R6: lowest index wins when both D0 and D2 match in supervisor mode
    lookup(1'b0, 1'b0, 32'h1000_0000);
    check(hit && realAddr == 32'h8000_0000 && perm == 3'b111, "R6 lowest index priority",
          {hit, miss, realAddr, perm}, {1'b1, 1'b0, 32'h8000_0000, 3'b111});

    // R10: zero-entry instance never hits
    lookup(1'b0, 1'b0, 32'h1001_2345);
    check(miss0 && !hit0 && realAddr0 == 0 && perm0 == 0, "R10 zero entries always miss",
          {hit0, miss0, realAddr0, perm0}, {1'b0, 1'b1, 32'h0, 3'b000});

    finishRun();
  end

endmodule